// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch or conditional move is taken. Each request presents a 4-bit condition selector, a mode bit choosing integer or floating-point evaluation, an integer flag nibble, a 2-bit floating-point comparison outcome and two enable status bits. One clock later the block returns a registered taken decision, a floating-point-disabled fault flag and a valid pulse.

Integer conditions are computed from carry, overflow, zero and negative flags. Floating-point conditions are computed from a four-valued outcome (equal, less, greater, unordered), where unordered is a real result. A floating-point request is only evaluated when both enable bits are set; otherwise the fault is raised and taken is forced low.

Top module: `bce_top`

## Requirements
- R1: Synchronous active-high reset clears out_vld, out_taken and out_fault.
- R2: out_vld pulses high exactly one clock after in_vld is sampled high, and is low otherwise; out_taken and out_fault are held while no result is produced.
- R3: Integer flag nibble layout: bit 0 carry C, bit 1 overflow V, bit 2 zero Z, bit 3 negative N.
- R4: Integer codes with bit 3 clear: 0 never, 1 Z, 2 Z|(N^V), 3 N^V, 4 C|Z, 5 C, 6 N, 7 V.
- R5: For every integer code with bit 3 set, the result is the exact complement of the code with bit 3 clear (8 always, 9 !Z, A !(Z|(N^V)), B !(N^V), C !(C|Z), D !C, E !N, F !V).
- R6: FP comparison outcome encoding: 0 equal E, 1 less L, 2 greater G, 3 unordered U.
- R7: FP codes 0..7: 0 never, 1 L|G|U, 2 L|G, 3 U|L, 4 L, 5 U|G, 6 G, 7 U.
- R8: FP codes 8..F: 8 always, 9 E, A U|E, B G|E, C U|G|E, D L|E, E U|L|E, F E|L|G.
- R9: An FP request (in_is_fp=1) is evaluated only when in_fp_en and in_fprs_fef are both 1; otherwise out_fault=1 and out_taken=0 for that request.
- R10: Integer requests never raise the fault, whatever the enable bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request valid |
| in_cond | input | 4 | Condition selector |
| in_is_fp | input | 1 | 1 selects floating-point evaluation |
| in_iflags | input | 4 | Integer flags {N,Z,V,C} |
| in_fcmp | input | 2 | FP comparison outcome |
| in_fp_en | input | 1 | Processor-state FP enable bit |
| in_fprs_fef | input | 1 | FP register-status enable bit |
| out_vld | output | 1 | Result valid pulse |
| out_taken | output | 1 | Condition holds |
| out_fault | output | 1 | FP-disabled fault |

## Verification
The embedded assertions check every cycle that the valid pulse follows the request by one clock, that a fault never coincides with taken, that integer requests never fault, that disabled FP requests always fault, and that the codes always and never resolve correctly. The correctness of each individual condition code against each flag and outcome combination, including the complement relation between integer code halves, is shown only by the bench sweeping all codes over all flag nibbles and all four FP outcomes.

// File: rtl/bce_pkg.sv
package bce_pkg;
    localparam int COND_W  = 4;
    localparam int IFLAG_W = 4;
    localparam int FCMP_W  = 2;

    typedef enum logic [1:0] {
        FCMP_EQ = 2'd0,
        FCMP_LT = 2'd1,
        FCMP_GT = 2'd2,
        FCMP_UN = 2'd3
    } fcmp_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } iflags_t;

    typedef struct packed {
        logic vld;
        logic taken;
        logic fault;
    } bce_result_t;

    // Base integer predicate for the lower half of the code space.
    function automatic logic int_base(input logic [2:0] sel, input iflags_t f);
        logic lt;
        lt = f.n ^ f.v;
        case (sel)
            3'd0:    return 1'b0;
            3'd1:    return f.z;
            3'd2:    return f.z | lt;
            3'd3:    return lt;
            3'd4:    return f.c | f.z;
            3'd5:    return f.c;
            3'd6:    return f.n;
            default: return f.v;
        endcase
    endfunction
endpackage

// File: rtl/bce_int_eval.sv
module bce_int_eval
    import bce_pkg::*;
(
    input  logic [COND_W-1:0]  cond,
    input  logic [IFLAG_W-1:0] flags,
    output logic               hit
);
    iflags_t f;
    logic    base;
    always_comb begin
        f    = iflags_t'(flags);
        base = int_base(cond[COND_W-2:0], f);
        hit  = base ^ cond[COND_W-1];
    end
endmodule

// File: rtl/bce_fp_eval.sv
module bce_fp_eval
    import bce_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic [FCMP_W-1:0] fcmp,
    output logic              hit
);
    // Each condition maps to a 4-bit accept mask over outcomes {U,G,L,E}.
    logic [3:0] outcome_oh;
    logic [3:0] accept;
    always_comb begin
        outcome_oh = 4'b0001 << fcmp;
        case (cond)
            4'h0: accept = 4'b0000;
            4'h1: accept = 4'b1110;
            4'h2: accept = 4'b0110;
            4'h3: accept = 4'b1010;
            4'h4: accept = 4'b0010;
            4'h5: accept = 4'b1100;
            4'h6: accept = 4'b0100;
            4'h7: accept = 4'b1000;
            4'h8: accept = 4'b1111;
            4'h9: accept = 4'b0001;
            4'hA: accept = 4'b1001;
            4'hB: accept = 4'b0101;
            4'hC: accept = 4'b1101;
            4'hD: accept = 4'b0011;
            4'hE: accept = 4'b1011;
            default: accept = 4'b0111;
        endcase
        hit = |(accept & outcome_oh);
    end
endmodule

// File: rtl/bce_top.sv
module bce_top
    import bce_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_vld,
    input  logic [COND_W-1:0]  in_cond,
    input  logic               in_is_fp,
    input  logic [IFLAG_W-1:0] in_iflags,
    input  logic [FCMP_W-1:0]  in_fcmp,
    input  logic               in_fp_en,
    input  logic               in_fprs_fef,
    output logic               out_vld,
    output logic               out_taken,
    output logic               out_fault
);
    logic        int_hit, fp_hit, fp_ok;
    bce_result_t nxt, res_q;

    bce_int_eval u_int (.cond(in_cond), .flags(in_iflags), .hit(int_hit));
    bce_fp_eval  u_fp  (.cond(in_cond), .fcmp(in_fcmp),    .hit(fp_hit));

    always_comb begin
        fp_ok     = in_fp_en & in_fprs_fef;
        nxt       = res_q;
        nxt.vld   = in_vld;
        if (in_vld) begin
            nxt.fault = in_is_fp & ~fp_ok;
            nxt.taken = in_is_fp ? (fp_hit & fp_ok) : int_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= nxt;
    end

    assign out_vld   = res_q.vld;
    assign out_taken = res_q.taken;
    assign out_fault = res_q.fault;

    assert_vld_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    assert_no_spurious_vld_R2: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(out_taken) && $stable(out_fault));
    assert_fault_not_taken_R9: assert property (@(posedge clk) disable iff (rst)
        out_fault |-> !out_taken);
    assert_disabled_fp_faults_R9: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_is_fp && !(in_fp_en && in_fprs_fef)) |=> out_fault);
    assert_int_no_fault_R10: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_is_fp) |=> !out_fault);
    assert_always_code_R5: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_is_fp && in_cond == 4'h8) |=> out_taken);
    assert_never_code_R4: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_cond == 4'h0) |=> !out_taken);
endmodule

// File: tb/test_bce_top.sv
module test_bce_top;
    logic clk = 1'b0;
    logic rst;
    logic in_vld, in_is_fp, in_fp_en, in_fprs_fef;
    logic [3:0] in_cond, in_iflags;
    logic [1:0] in_fcmp;
    logic out_vld, out_taken, out_fault;

    int n_tests = 0, n_fail = 0;
    logic [7:0] exp_q[$];   // {tag[5:0], taken, fault}; tag: req id
    bit done = 0;

    always #2.5 clk = ~clk;

    bce_top i_bce_top (.*);

    function automatic logic ref_int(input logic [3:0] c, input logic [3:0] f);
        logic C, V, Z, N, b;
        C = f[0]; V = f[1]; Z = f[2]; N = f[3];
        case (c[2:0])
            3'd0: b = 0;
            3'd1: b = Z;
            3'd2: b = Z | (N ^ V);
            3'd3: b = N ^ V;
            3'd4: b = C | Z;
            3'd5: b = C;
            3'd6: b = N;
            default: b = V;
        endcase
        return c[3] ? ~b : b;
    endfunction

    function automatic logic ref_fp(input logic [3:0] c, input logic [1:0] o);
        logic E, L, G, U;
        E = (o == 0); L = (o == 1); G = (o == 2); U = (o == 3);
        case (c)
            4'h0: return 0;           4'h1: return L | G | U;
            4'h2: return L | G;       4'h3: return U | L;
            4'h4: return L;           4'h5: return U | G;
            4'h6: return G;           4'h7: return U;
            4'h8: return 1;           4'h9: return E;
            4'hA: return U | E;       4'hB: return G | E;
            4'hC: return U | G | E;   4'hD: return L | E;
            4'hE: return U | L | E;   default: return E | L | G;
        endcase
    endfunction

    // Requirement tag per expectation: 4 int, 5 int upper, 7/8 fp, 9 fault, 10 int-with-disabled
    task automatic drive(input logic fp, input logic [3:0] c, input logic [3:0] f,
                         input logic [1:0] o, input logic en, input logic fef, input int req);
        logic t, flt;
        @(negedge clk);
        in_vld = 1; in_is_fp = fp; in_cond = c; in_iflags = f; in_fcmp = o;
        in_fp_en = en; in_fprs_fef = fef;
        if (fp) begin
            flt = ~(en & fef);
            t   = flt ? 1'b0 : ref_fp(c, o);
        end else begin
            flt = 0;
            t   = ref_int(c, f);
        end
        exp_q.push_back({req[5:0], t, flt});
    endtask

    // Monitor: compare at negedge after each result register update
    always @(negedge clk) begin
        if (!rst && out_vld) begin
            logic [7:0] e;
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2: unexpected out_vld act=1 exp=0");
            end else begin
                e = exp_q.pop_front();
                if ({out_taken, out_fault} !== e[1:0]) begin
                    n_fail++;
                    $display("FAIL R%0d: taken/fault act=%b%b exp=%b%b", e[7:2],
                             out_taken, out_fault, e[1], e[0]);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic pt, pf;
        rst = 1; in_vld = 0; in_is_fp = 0; in_cond = 0; in_iflags = 0;
        in_fcmp = 0; in_fp_en = 0; in_fprs_fef = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_tests++;
        if ({out_vld, out_taken, out_fault} !== 3'b000) begin
            n_fail++;
            $display("FAIL R1: reset outs act=%b exp=000", {out_vld, out_taken, out_fault});
        end
        @(negedge clk); rst = 0;

        // R3 R4 R5: all integer codes over all flag nibbles
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 16; f++)
                drive(0, c[3:0], f[3:0], 2'd0, 1'b1, 1'b1, c[3] ? 5 : 4);
        // R5: complement relation checked directly against the reference pairs
        for (int c = 0; c < 8; c++)
            for (int f = 0; f < 16; f++) begin
                n_tests++;
                if (ref_int(c[3:0] | 4'h8, f[3:0]) !== ~ref_int(c[3:0], f[3:0])) begin
                    n_fail++;
                    $display("FAIL R5: complement code %0d act=%b exp=%b", c,
                             ref_int(c[3:0] | 4'h8, f[3:0]), ~ref_int(c[3:0], f[3:0]));
                end
            end
        // R6 R7 R8: FP codes over all outcomes, enabled
        for (int c = 0; c < 16; c++)
            for (int o = 0; o < 4; o++)
                drive(1, c[3:0], 4'h0, o[1:0], 1'b1, 1'b1, c < 8 ? 7 : 8);
        // R9: each disabled enable combination
        for (int c = 0; c < 16; c++)
            for (int e = 0; e < 3; e++)
                drive(1, c[3:0], 4'h0, 2'd0, e[1], e[0], 9);
        // R10: integer with enables off
        for (int c = 0; c < 16; c++)
            drive(0, c[3:0], 4'b0101, 2'd3, 1'b0, 1'b0, 10);
        @(negedge clk); in_vld = 0;
        // R2: idle - outputs hold, no valid
        pt = out_taken; pf = out_fault;
        drive(0, 4'h8, 4'h0, 2'd0, 1'b0, 1'b0, 2);
        @(negedge clk); in_vld = 0;
        @(negedge clk);
        pt = out_taken; pf = out_fault;
        repeat (4) begin
            in_cond = 4'h0; in_is_fp = 1; in_fp_en = 0;
            @(negedge clk);
            n_tests++;
            if ({out_taken, out_fault} !== {pt, pf}) begin
                n_fail++;
                $display("FAIL R2: idle hold act=%b%b exp=%b%b", out_taken, out_fault, pt, pf);
            end
        end
        // R1: reset mid-stream clears outputs
        drive(1, 4'h8, 4'h0, 2'd0, 1'b0, 1'b0, 9);
        @(negedge clk); in_vld = 0;
        void'(exp_q.pop_front());
        rst = 1;
        @(negedge clk);
        n_tests++;
        if ({out_vld, out_taken, out_fault} !== 3'b000) begin
            n_fail++;
            $display("FAIL R1: reset clear act=%b exp=000", {out_vld, out_taken, out_fault});
        end
        rst = 0;
        repeat (2) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: missing results act=%0d exp=0", exp_q.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule